// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This block sits between a processor core and a data memory that is one 32-bit word wide but addressed in bytes. On a store it converts the core's byte address, access size and data into a word address, a set of per-lane write strobes and lane-placed write data. On a load it records how the request was decoded. When the memory returns the whole word one cycle later, the block picks the addressed byte or halfword out of that word and widens it to 32 bits, either with the sign bit copied upward or with zeros.

A mode input chooses how byte addresses map onto the lanes of the memory word. In little-endian mode, byte offset k within a word lives in lane k. In big-endian mode it lives in lane 3-k, so the most significant byte sits at the lowest address. Halfword and word accesses must be naturally aligned. The block raises a misalign flag for any access that breaks this rule, and also for the reserved size code. In either case it withholds the memory request and all strobes.

Lane i of the memory word is bits 8i+7 down to 8i. The size code is 00 for a byte, 01 for a halfword, 10 for a word and 11 reserved.

Top module: `lsu_align_top`

## Requirements
- R1: mem_addr equals req_addr with its two low bits forced to zero, combinationally in the request cycle.
- R2: In little-endian mode (big_endian=0), an accepted store sets these strobes on mem_be. A byte at offset k sets bit k only. A halfword at offset 0 sets 0011 and at offset 2 sets 1100. A word sets 1111. Loads and idle cycles drive mem_be to 0000.
- R3: In big-endian mode (big_endian=1), an accepted store sets these strobes on mem_be. A byte at offset k sets bit 3-k only. A halfword at offset 0 sets 1100 and at offset 2 sets 0011. A word sets 1111.
- R4: For an accepted store, mem_wdata has the following form. A byte store carries req_wdata[7:0] in all four lanes. A halfword store carries req_wdata[15:0] in both halves. A word store carries req_wdata unchanged.
- R5: misalign is 1 for a valid request in any of these cases: a halfword with address bit 0 set, a word with either low address bit set, or size code 11. While misalign is 1, mem_be is 0000 and mem_req is 0.
- R6: mem_req is req_valid and not misalign, and mem_we is mem_req and req_write. When req_valid is 0, mem_req, mem_we, misalign and mem_be are all 0.
- R7: ld_valid is 1 in the cycle after an accepted load exactly when rd_valid is 1 in that cycle. It is 0 at all other times, including during reset. ld_data is formed combinationally from rd_word in that same cycle.
- R8: Sub-word loads take the addressed bytes from the lanes given by R2/R3. For example, with rd_word=0x87654321, unsigned byte loads at offsets 0 to 3 return 87, 65, 43, 21 in big-endian mode and 21, 43, 65, 87 in little-endian mode. An unsigned halfword load at offset 0 returns 0x8765 in big-endian mode and 0x4321 in little-endian mode.
- R9: With req_unsigned=0, a byte or halfword load copies bit 7 or bit 15 of the loaded value into all higher bits of ld_data.
- R10: With req_unsigned=1, a byte or halfword load sets all bits of ld_data above the loaded value to zero.
- R11: A word load returns rd_word unchanged in either mode, whatever the value of req_unsigned.
- R12: A misaligned load produces no ld_valid in the following cycle, even if rd_valid is 1.
- R13: The lane mapping and extension used for a load are those in force in the request cycle. Changing big_endian in the response cycle has no effect on ld_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | 1 selects big-endian lane mapping, 0 little-endian |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | 1 zero-extends sub-word loads, 0 sign-extends |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_req | output | 1 | Access issued to memory |
| mem_we | output | 1 | Issued access is a write |
| mem_be | output | 4 | Per-lane write strobes |
| mem_wdata | output | 32 | Lane-placed write data |
| misalign | output | 1 | Request is misaligned or has the reserved size |
| rd_valid | input | 1 | Memory read word valid |
| rd_word | input | 32 | Word returned by memory |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load result |

## Verification
The address, strobe, write-data, request and misalign outputs are combinational, so they are due in the same cycle as the request. The bench drives each request on a falling edge and samples these outputs one nanosecond later, well before the next rising edge. Load results are due in the following cycle, once the captured decode has passed its single register stage. The bench therefore applies the returned word on the next falling edge, sets req_valid low and inverts big_endian at the same moment, and then samples ld_valid and ld_data. A behavioural model maps each byte address to a lane and builds the expected value byte by byte, and every cycle of every access is compared against it.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_align_decode.sv
module lsu_align_decode
  import lsu_align_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic             valid,
  input  logic             big,
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             mis,
  output logic [OFF_W:0]   nbytes,
  output logic [LANES-1:0] lane_mask,
  output logic [OFF_W-1:0] low_lane
);
  logic [OFF_W:0] be_base;

  always_comb begin
    case (size)
      SZ_BYTE: nbytes = (OFF_W+1)'(1);
      SZ_HALF: nbytes = (OFF_W+1)'(2);
      default: nbytes = (OFF_W+1)'(LANES);
    endcase
  end

  always_comb begin
    mis = 1'b0;
    if (valid) begin
      case (size)
        SZ_HALF: mis = off[0];
        SZ_WORD: mis = (off != '0);
        SZ_RSVD: mis = 1'b1;
        default: mis = 1'b0;
      endcase
    end
  end

  // lowest lane touched: offset itself for little endian, mirrored for big
  assign be_base  = (OFF_W+1)'(LANES) - nbytes - {1'b0, off};
  assign low_lane = big ? be_base[OFF_W-1:0] : off;

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign lane_mask[i] = ((OFF_W+1)'(i) < nbytes);
  end
endmodule

// File: rtl/lsu_align_store.sv
module lsu_align_store
  import lsu_align_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = 8 * LANES
) (
  input  logic              en,
  input  acc_size_e         size,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [OFF_W-1:0]  low_lane,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_data
);
  assign be = en ? (lane_mask << low_lane) : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      case (size)
        SZ_BYTE: lane_data[8*i +: 8] = wdata[7:0];
        SZ_HALF: lane_data[8*i +: 8] = wdata[8*(i % 2) +: 8];
        default: lane_data[8*i +: 8] = wdata[8*i +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_align_load.sv
module lsu_align_load #(
  parameter int LANES = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              uns,
  input  logic [OFF_W:0]    nbytes,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [OFF_W-1:0]  low_lane,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_word,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  logic             pend_q, pend_d;
  logic             uns_q, uns_d;
  logic [LANES-1:0] mask_q, mask_d;
  logic [OFF_W-1:0] low_q, low_d;
  logic [OFF_W-1:0] hi_q, hi_d;
  logic             cap_en;
  logic             ext_bit;

  assign cap_en = accept;

  always_comb begin
    pend_d = accept;
    uns_d  = uns;
    mask_d = lane_mask;
    low_d  = low_lane;
    hi_d   = low_lane + OFF_W'(nbytes - (OFF_W+1)'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      uns_q  <= 1'b0;
      mask_q <= '0;
      low_q  <= '0;
      hi_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (cap_en) begin
        uns_q  <= uns_d;
        mask_q <= mask_d;
        low_q  <= low_d;
        hi_q   <= hi_d;
      end
    end
  end

  assign ld_valid = rd_valid & pend_q;
  assign ext_bit  = ~uns_q & rd_word[8*int'(hi_q) + 7];

  always_comb begin
    logic [OFF_W-1:0] src;
    ld_data = '0;
    for (int j = 0; j < LANES; j++) begin
      src = low_q + OFF_W'(j);
      if (mask_q[j]) ld_data[8*j +: 8] = rd_word[8*int'(src) +: 8];
      else           ld_data[8*j +: 8] = {8{ext_bit}};
    end
  end
endmodule

// File: rtl/lsu_align_top.sv
module lsu_align_top
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              misalign,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_word,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  acc_size_e        size;
  logic             mis;
  logic [OFF_W:0]   nbytes;
  logic [LANES-1:0] lane_mask;
  logic [OFF_W-1:0] low_lane;
  logic             st_en;
  logic             ld_acc;

  assign size = acc_size_e'(req_size);

  lsu_align_decode #(.LANES(LANES)) dec_i (
    .valid     (req_valid),
    .big       (big_endian),
    .size      (size),
    .off       (req_addr[OFF_W-1:0]),
    .mis       (mis),
    .nbytes    (nbytes),
    .lane_mask (lane_mask),
    .low_lane  (low_lane)
  );

  assign mem_req  = req_valid & ~mis;
  assign mem_we   = mem_req & req_write;
  assign misalign = mis;
  assign st_en    = mem_we;
  assign ld_acc   = mem_req & ~req_write;
  assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  lsu_align_store #(.LANES(LANES)) st_i (
    .en        (st_en),
    .size      (size),
    .lane_mask (lane_mask),
    .low_lane  (low_lane),
    .wdata     (req_wdata),
    .be        (mem_be),
    .lane_data (mem_wdata)
  );

  lsu_align_load #(.LANES(LANES)) ld_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ld_acc),
    .uns       (req_unsigned),
    .nbytes    (nbytes),
    .lane_mask (lane_mask),
    .low_lane  (low_lane),
    .rd_valid  (rd_valid),
    .rd_word   (rd_word),
    .ld_valid  (ld_valid),
    .ld_data   (ld_data)
  );
endmodule

// File: rtl/lsu_align_sva.sv
module lsu_align_sva #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = 8 * LANES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic              req_unsigned,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [LANES-1:0]  mem_be,
  input logic              misalign,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data
);
  int exp_cnt;
  always_comb begin
    case (req_size)
      2'b00:   exp_cnt = 1;
      2'b01:   exp_cnt = 2;
      default: exp_cnt = LANES;
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_req && !mem_we && !misalign && mem_be == '0)); // R6

  AST_MIS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == '0 && !mem_req)); // R5

  AST_WORD_MIS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b10 && req_addr[OFF_W-1:0] != '0) |-> misalign); // R5

  AST_STORE_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == exp_cnt)); // R2

  AST_LD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_req && !mem_we)); // R7

  AST_LD_UNS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(mem_req && !mem_we && req_size == 2'b00 && req_unsigned))
      |-> (ld_data[DATA_W-1:8] == '0)); // R10
endmodule

bind lsu_align_top lsu_align_sva #(.ADDR_W(ADDR_W), .LANES(LANES)) sva_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_size     (req_size),
  .req_unsigned (req_unsigned),
  .req_addr     (req_addr),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_be       (mem_be),
  .misalign     (misalign),
  .ld_valid     (ld_valid),
  .ld_data      (ld_data)
);

// File: tb/lsu_align_top_tb_top.sv
`timescale 1ns/1ps
module lsu_align_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        big_endian, req_valid, req_write, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_req, mem_we, misalign;
  logic [3:0]  mem_be;
  logic        rd_valid;
  logic [31:0] rd_word;
  logic        ld_valid;
  logic [31:0] ld_data;

  int n_cmp = 0;
  int n_mis = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  lsu_align_top dut_i (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_unsigned(req_unsigned), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .misalign(misalign), .rd_valid(rd_valid),
    .rd_word(rd_word), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] s);
    case (s)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_mis(input logic [1:0] s, input logic [31:0] a);
    return (s == 2'b11) || (s == 2'b01 && a[0]) || (s == 2'b10 && a[1:0] != 2'b00);
  endfunction

  function automatic int lane_of(input int byte_off, input bit big);
    return big ? 3 - byte_off : byte_off;
  endfunction

  function automatic logic [3:0] m_be(input bit wr, input logic [1:0] s,
                                      input logic [31:0] a, input bit big);
    logic [3:0] be = 4'b0000;
    if (wr && !m_mis(s, a))
      for (int b = 0; b < nbytes(s); b++) be[lane_of(int'(a[1:0]) + b, big)] = 1'b1;
    return be;
  endfunction

  function automatic logic [31:0] m_wdata(input logic [1:0] s, input logic [31:0] d);
    case (s)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] m_load(input logic [1:0] s, input bit uns,
                                         input logic [31:0] a, input bit big,
                                         input logic [31:0] w);
    logic [31:0] v = 32'h0;
    int n = nbytes(s);
    for (int b = 0; b < n; b++) begin
      logic [7:0] bv = w[8*lane_of(int'(a[1:0]) + b, big) +: 8];
      if (big) v = (v << 8) | {24'h0, bv};
      else     v = v | ({24'h0, bv} << (8*b));
    end
    if (n < 4 && !uns && v[8*n-1]) v = v | ~((32'h1 << (8*n)) - 32'h1);
    return v;
  endfunction

  task automatic op(input bit wr, input logic [1:0] sz, input bit uns,
                    input logic [31:0] addr, input logic [31:0] wd, input bit big,
                    input bit rdv, input logic [31:0] word, input string tag);
    bit mis_e;
    bit ldv_e;
    string dtag;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_unsigned = uns;
    req_addr = addr; req_wdata = wd; big_endian = big; rd_valid = 1'b0;
    #1;
    mis_e = m_mis(sz, addr);
    chk("R1", mem_addr, {addr[31:2], 2'b00});
    chk("R5", {31'h0, misalign}, {31'h0, mis_e});
    chk("R6", {30'h0, mem_req, mem_we}, {30'h0, !mis_e, wr && !mis_e});
    chk(big ? "R3" : "R2", {28'h0, mem_be}, {28'h0, m_be(wr, sz, addr, big)});
    if (wr && !mis_e) chk("R4", mem_wdata, m_wdata(sz, wd));
    chk("R7", {31'h0, ld_valid}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0; rd_valid = rdv; rd_word = word; big_endian = ~big;
    #1;
    ldv_e = !wr && !mis_e && rdv;
    chk(mis_e ? "R12" : "R7", {31'h0, ld_valid}, {31'h0, ldv_e});
    if (ldv_e) begin
      if (tag != "")         dtag = tag;
      else if (sz == 2'b10)  dtag = "R11";
      else if (uns)          dtag = "R10";
      else                   dtag = "R9";
      chk(dtag, ld_data, m_load(sz, uns, addr, big, word));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; big_endian = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_size = 2'b00; req_unsigned = 1'b0; req_addr = '0; req_wdata = '0;
    rd_valid = 1'b1; rd_word = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R7", {31'h0, ld_valid}, 32'h0);
    chk("R6", {28'h0, mem_req, mem_we, misalign, 1'b0}, 32'h0);
    chk("R6", {28'h0, mem_be}, 32'h0);
    rst_n = 1'b1;
    rd_valid = 1'b0;

    for (int k = 0; k < 4; k++) begin
      op(0, 2'b00, 1, 32'h100 + k, 0, 1, 1, 32'h8765_4321, "R8");
      op(0, 2'b00, 1, 32'h100 + k, 0, 0, 1, 32'h8765_4321, "R8");
    end
    op(0, 2'b01, 1, 32'h200, 0, 1, 1, 32'h8765_4321, "R8");
    op(0, 2'b01, 1, 32'h200, 0, 0, 1, 32'h8765_4321, "R8");
    op(0, 2'b00, 0, 32'h300, 0, 1, 1, 32'h8765_4321, "R9");
    op(0, 2'b01, 0, 32'h302, 0, 0, 1, 32'h8765_4321, "R9");
    op(0, 2'b01, 0, 32'h300, 0, 0, 1, 32'h8765_4321, "R9");
    op(0, 2'b01, 1, 32'h302, 0, 0, 1, 32'hF00D_8001, "R10");
    op(0, 2'b10, 0, 32'h400, 0, 1, 1, 32'h8765_4321, "R11");
    op(0, 2'b10, 1, 32'h404, 0, 0, 1, 32'hDEAD_BEEF, "R11");
    op(0, 2'b00, 0, 32'h501, 0, 1, 1, 32'h1122_3344, "R13");
    for (int k = 0; k < 4; k++) begin
      op(1, 2'b00, 0, 32'h600 + k, 32'h0000_00A5, 0, 0, 0, "");
      op(1, 2'b00, 0, 32'h600 + k, 32'h0000_005A, 1, 0, 0, "");
    end
    op(1, 2'b01, 0, 32'h700, 32'h0000_BEEF, 0, 0, 0, "");
    op(1, 2'b01, 0, 32'h702, 32'h0000_BEEF, 1, 0, 0, "");
    op(1, 2'b10, 0, 32'h704, 32'h8765_4321, 1, 0, 0, "");
    op(1, 2'b01, 0, 32'h801, 32'h1234_5678, 0, 0, 0, "");
    op(1, 2'b10, 0, 32'h802, 32'h1234_5678, 1, 0, 0, "");
    op(1, 2'b11, 0, 32'h800, 32'h1234_5678, 0, 0, 0, "");
    op(0, 2'b10, 0, 32'h803, 0, 0, 1, 32'h1234_5678, "R12");
    op(0, 2'b01, 0, 32'h803, 0, 1, 1, 32'h1234_5678, "R12");
    op(0, 2'b00, 0, 32'h900, 0, 0, 0, 32'h1234_5678, "R7");

    for (int i = 0; i < 1500; i++) begin
      op(1'($urandom), 2'($urandom), 1'($urandom), $urandom, $urandom,
         1'($urandom), 1'($urandom), $urandom, "");
    end

    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule